// File: doc/BRIEF.md
# Set-Associative Cache Controller

A small cache placed between a processor request port and a slower word-wide main-memory port. Each request address is cut into three fields: a tag in the upper bits, a set number in the middle and a word offset within the block in the low bits. The set number picks one set directly. The stored tags of every way in that set are then compared in parallel with the request tag. A match in a valid way is a hit, and the access is served from the way that matched, the set number and the offset.

On a miss, the controller picks the least recently used way of the set. If the cache runs in write-back mode and that line is dirty, the line is first written out word by word. The whole block is then fetched word by word from memory, and the request is looked up again and completes. A compile-time parameter picks one of two write policies. Write-back mode allocates a line on a write miss. Write-through mode sends every write to memory and does not allocate on a write miss.

Both ports use a valid/ready handshake, and only one processor request is in flight at a time. When the way count is one, the cache is direct mapped and no replacement choice is made.

Top module: `cache_ctrl`

## Requirements
- R1: A word address is split as offset = bits [OFF_W-1:0], set = the next SET_W bits, and tag = the remaining upper bits. With the default sizes, offset = addr[1:0], set = addr[3:2] and tag = addr[9:4]. Addresses in one block share a line, and the same tag in a different set is a different line.
- R2: A read that hits returns the stored word with `cpu_rsp_hit`=1 and makes no memory request.
- R3: A read miss reads all LINE_WORDS words of the block from memory (offsets 0 upward, at the block's base address), then returns the requested word with `cpu_rsp_hit`=0.
- R4: On a miss, the line that is replaced is the way of that set least recently touched by a hit, a fill or a write. Every such access makes its way the most recent.
- R5: In write-back mode (WRITE_BACK=1), a write hit updates only the cache and issues no memory write. A modified line is written back as LINE_WORDS memory writes only when it is evicted, and a clean victim causes no memory write.
- R6: In write-back mode, a write miss fetches the block (LINE_WORDS reads) and then merges the store into the cache, responding with `cpu_rsp_hit`=0 and issuing no memory write.
- R7: In write-through mode (WRITE_BACK=0), every write issues exactly one memory write of that word at its address. A write miss reads nothing and does not allocate, so a later read of that address misses.
- R8: `cpu_req_ready` is high only while no request is in flight. A memory request keeps its valid, address and write flag unchanged until it is accepted. No memory request is raised while idle.
- R9: Each accepted request produces exactly one response, and `cpu_rsp_valid` is high for one cycle.
- R10: After reset every line is invalid, `cpu_req_ready`=1 and `cpu_rsp_valid`=0, so the first access to any block misses.
- R11: With WAYS=1 the cache is direct mapped. A miss overwrites the single resident line of the set unconditionally, so two blocks of one set evict each other. A dirty resident line is written back first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Controller can accept a request |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_rsp_valid | output | 1 | One-cycle response pulse |
| cpu_rsp_rdata | output | DATA_W | Read data |
| cpu_rsp_hit | output | 1 | 1 if the request hit without a refill |
| mem_req_valid | output | 1 | Memory word request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_req_addr | output | ADDR_W | Memory word address |
| mem_req_wdata | output | DATA_W | Memory write data |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | DATA_W | Returned read word |

## Verification
In write-back mode, the refill that follows a write miss and the merging of the store into the new line fall in the same lookup cycle. In that cycle the line becomes valid, becomes dirty and becomes most recent. The bench provokes this by writing to a set whose victim is clean, then forcing that line out with two further misses. It judges the result by three observations: the word read back from the cache, the number of memory writes seen at eviction, and the content of the backing memory after eviction. A direct-mapped instance repeats the case, with a dirty resident line evicted by a conflicting read.

// File: rtl/cache_pkg.sv
package cache_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_EVICT,
        ST_FILL_REQ,
        ST_FILL_WAIT,
        ST_WT_WRITE,
        ST_DONE
    } cache_state_e;

    // index width for a count, never below one bit
    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/cache_match.sv
module cache_match
    import cache_pkg::*;
#(
    parameter int unsigned WAYS  = 2,
    parameter int unsigned TAG_W = 6,
    localparam int unsigned WAY_W = idx_w(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        check_en,
    input  logic [WAYS-1:0][TAG_W-1:0]  way_tags,
    input  logic [WAYS-1:0]             way_valid,
    input  logic [TAG_W-1:0]            req_tag,
    output logic                        hit,
    output logic [WAY_W-1:0]            hit_way
);
    logic [WAYS-1:0] hit_vec;

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            hit_vec[w] = way_valid[w] && (way_tags[w] == req_tag);
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
        hit = |hit_vec;
    end

    // R1
    single_match_chk: assert property (@(posedge clk) disable iff (rst)
        check_en |-> $onehot0(hit_vec));

endmodule

// File: rtl/cache_lru.sv
module cache_lru
    import cache_pkg::*;
#(
    parameter int unsigned SETS = 4,
    parameter int unsigned WAYS = 2,
    localparam int unsigned SET_W = idx_w(SETS),
    localparam int unsigned WAY_W = idx_w(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             touch_en,
    input  logic [SET_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way,
    input  logic [SET_W-1:0] query_set,
    output logic [WAY_W-1:0] victim
);
    generate
        if (WAYS == 1) begin : g_direct
            assign victim = '0;
        end else begin : g_ages
            // age 0 = most recent, WAYS-1 = least recent; ages form a permutation
            logic [WAYS-1:0][WAY_W-1:0] age_q [SETS];
            logic [WAYS-1:0]            oldest;

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int s = 0; s < SETS; s++)
                        for (int w = 0; w < WAYS; w++)
                            age_q[s][w] <= WAY_W'(w);
                end else if (touch_en) begin
                    for (int w = 0; w < WAYS; w++) begin
                        if (WAY_W'(w) == touch_way)
                            age_q[touch_set][w] <= '0;
                        else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
                            age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
                    end
                end
            end

            always_comb begin
                victim = '0;
                for (int w = 0; w < WAYS; w++) begin
                    oldest[w] = (age_q[query_set][w] == WAY_W'(WAYS - 1));
                    if (oldest[w]) victim = WAY_W'(w);
                end
            end

            // R4
            lru_unique_chk: assert property (@(posedge clk) disable iff (rst)
                $onehot(oldest));
        end
    endgenerate

endmodule

// File: rtl/cache_data.sv
module cache_data
    import cache_pkg::*;
#(
    parameter int unsigned SETS       = 4,
    parameter int unsigned WAYS       = 2,
    parameter int unsigned LINE_WORDS = 4,
    parameter int unsigned DATA_W     = 32,
    localparam int unsigned SET_W = idx_w(SETS),
    localparam int unsigned WAY_W = idx_w(WAYS),
    localparam int unsigned OFF_W = idx_w(LINE_WORDS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SET_W-1:0]  rd_set,
    input  logic [WAY_W-1:0]  rd_way,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] store_q [SETS][WAYS][LINE_WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) store_q[wr_set][wr_way][wr_off] <= wr_data;
    end

    assign rd_data = store_q[rd_set][rd_way][rd_off];

endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
    import cache_pkg::*;
#(
    parameter int unsigned ADDR_W     = 10,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned SETS       = 4,
    parameter int unsigned WAYS       = 2,
    parameter int unsigned LINE_WORDS = 4,
    parameter bit          WRITE_BACK = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_we,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_rsp_valid,
    output logic [DATA_W-1:0] cpu_rsp_rdata,
    output logic              cpu_rsp_hit,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata
);
    localparam int unsigned OFF_W = idx_w(LINE_WORDS);
    localparam int unsigned SET_W = idx_w(SETS);
    localparam int unsigned WAY_W = idx_w(WAYS);
    localparam int unsigned TAG_W = ADDR_W - SET_W - OFF_W;
    localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(LINE_WORDS - 1);

    typedef struct packed {
        logic              we;
        logic [TAG_W-1:0]  tag;
        logic [SET_W-1:0]  set;
        logic [OFF_W-1:0]  off;
        logic [DATA_W-1:0] wdata;
    } req_t;

    cache_state_e state_q;
    req_t         req_q;
    logic [OFF_W-1:0] beat_q;
    logic [WAY_W-1:0] vict_q;
    logic             missed_q;
    logic [DATA_W-1:0] rdata_q;

    logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
    logic [WAYS-1:0]            valid_q [SETS];
    logic [WAYS-1:0]            dirty_q [SETS];

    logic             hit;
    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] lru_victim;
    logic             in_lookup;
    logic             vict_dirty;
    logic             dw_en;
    logic [WAY_W-1:0] dw_way, rd_way;
    logic [OFF_W-1:0] dw_off, rd_off;
    logic [DATA_W-1:0] dw_data, rd_data;

    assign in_lookup  = (state_q == ST_LOOKUP);
    assign vict_dirty = WRITE_BACK && valid_q[req_q.set][lru_victim]
                        && dirty_q[req_q.set][lru_victim];

    cache_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .clk(clk), .rst(rst), .check_en(in_lookup),
        .way_tags(tag_q[req_q.set]), .way_valid(valid_q[req_q.set]),
        .req_tag(req_q.tag), .hit(hit), .hit_way(hit_way)
    );

    cache_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
        .clk(clk), .rst(rst),
        .touch_en(in_lookup && hit), .touch_set(req_q.set), .touch_way(hit_way),
        .query_set(req_q.set), .victim(lru_victim)
    );

    always_comb begin
        dw_en   = (in_lookup && hit && req_q.we) || (state_q == ST_FILL_WAIT && mem_rsp_valid);
        dw_way  = in_lookup ? hit_way : vict_q;
        dw_off  = in_lookup ? req_q.off : beat_q;
        dw_data = in_lookup ? req_q.wdata : mem_rsp_rdata;
        rd_way  = (state_q == ST_EVICT) ? vict_q : hit_way;
        rd_off  = (state_q == ST_EVICT) ? beat_q : req_q.off;
    end

    cache_data #(.SETS(SETS), .WAYS(WAYS), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)) u_data (
        .clk(clk), .wr_en(dw_en), .wr_set(req_q.set), .wr_way(dw_way), .wr_off(dw_off),
        .wr_data(dw_data), .rd_set(req_q.set), .rd_way(rd_way), .rd_off(rd_off),
        .rd_data(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            req_q    <= '0;
            beat_q   <= '0;
            vict_q   <= '0;
            missed_q <= 1'b0;
            rdata_q  <= '0;
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
                tag_q[s]   <= '0;
            end
        end else begin
            unique case (state_q)
                ST_IDLE: if (cpu_req_valid) begin
                    req_q    <= '{we: cpu_req_we, tag: cpu_req_addr[ADDR_W-1 -: TAG_W],
                                  set: cpu_req_addr[OFF_W +: SET_W],
                                  off: cpu_req_addr[OFF_W-1:0], wdata: cpu_req_wdata};
                    missed_q <= 1'b0;
                    state_q  <= ST_LOOKUP;
                end
                ST_LOOKUP: begin
                    if (hit) begin
                        if (!req_q.we) begin
                            rdata_q <= rd_data;
                            state_q <= ST_DONE;
                        end else if (WRITE_BACK) begin
                            dirty_q[req_q.set][hit_way] <= 1'b1;
                            state_q <= ST_DONE;
                        end else begin
                            state_q <= ST_WT_WRITE;
                        end
                    end else if (!req_q.we || WRITE_BACK) begin
                        missed_q <= 1'b1;
                        vict_q   <= lru_victim;
                        beat_q   <= '0;
                        valid_q[req_q.set][lru_victim] <= 1'b0;
                        state_q  <= vict_dirty ? ST_EVICT : ST_FILL_REQ;
                    end else begin
                        missed_q <= 1'b1;
                        state_q  <= ST_WT_WRITE;
                    end
                end
                ST_EVICT: if (mem_req_ready) begin
                    beat_q <= beat_q + 1'b1;
                    if (beat_q == LAST_BEAT) begin
                        beat_q <= '0;
                        dirty_q[req_q.set][vict_q] <= 1'b0;
                        state_q <= ST_FILL_REQ;
                    end
                end
                ST_FILL_REQ: if (mem_req_ready) state_q <= ST_FILL_WAIT;
                ST_FILL_WAIT: if (mem_rsp_valid) begin
                    beat_q <= beat_q + 1'b1;
                    if (beat_q == LAST_BEAT) begin
                        tag_q[req_q.set][vict_q]   <= req_q.tag;
                        valid_q[req_q.set][vict_q] <= 1'b1;
                        dirty_q[req_q.set][vict_q] <= 1'b0;
                        state_q <= ST_LOOKUP;
                    end else begin
                        state_q <= ST_FILL_REQ;
                    end
                end
                ST_WT_WRITE: if (mem_req_ready) state_q <= ST_DONE;
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cpu_req_ready = (state_q == ST_IDLE);
        cpu_rsp_valid = (state_q == ST_DONE);
        cpu_rsp_rdata = rdata_q;
        cpu_rsp_hit   = !missed_q;
        mem_req_valid = (state_q == ST_EVICT) || (state_q == ST_FILL_REQ) || (state_q == ST_WT_WRITE);
        mem_req_we    = (state_q == ST_EVICT) || (state_q == ST_WT_WRITE);
        mem_req_wdata = (state_q == ST_EVICT) ? rd_data : req_q.wdata;
        unique case (state_q)
            ST_EVICT:    mem_req_addr = {tag_q[req_q.set][vict_q], req_q.set, beat_q};
            ST_FILL_REQ: mem_req_addr = {req_q.tag, req_q.set, beat_q};
            default:     mem_req_addr = {req_q.tag, req_q.set, req_q.off};
        endcase
    end

    // R8
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_req_ready |-> !mem_req_valid && !cpu_rsp_valid);

    // R9
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_rsp_valid |=> !cpu_rsp_valid);

    // R7
    wt_store_only_chk: assert property (@(posedge clk) disable iff (rst)
        (WRITE_BACK == 1'b0) && mem_req_valid && mem_req_we |-> req_q.we);

endmodule

// File: tb/sim_cache_ctrl.sv
`timescale 1ns/1ps
module sim_cache_ctrl;
    localparam int N  = 3;   // 0: write-back 2-way, 1: write-through 2-way, 2: write-back direct mapped
    localparam int AW = 10;
    localparam int DW = 32;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst;
    always #2.5 clk = ~clk;

    logic          req_valid [N];
    logic          req_we    [N];
    logic [AW-1:0] req_addr  [N];
    logic [DW-1:0] req_wdata [N];
    logic          req_ready [N];
    logic          rsp_valid [N];
    logic [DW-1:0] rsp_rdata [N];
    logic          rsp_hit   [N];
    logic          mreq_valid [N];
    logic          mreq_ready [N];
    logic          mreq_we    [N];
    logic [AW-1:0] mreq_addr  [N];
    logic [DW-1:0] mreq_wdata [N];
    logic          mrsp_valid [N];
    logic [DW-1:0] mrsp_rdata [N];

    logic [DW-1:0] mem_b   [N][DEPTH];
    logic [DW-1:0] ref_mem [N][DEPTH];
    logic          pend    [N];
    logic [AW-1:0] pend_addr [N];
    int            mem_rd_cnt [N];
    int            mem_wr_cnt [N];
    int            rsp_cnt    [N];
    int            req_cnt    [N];

    int tests = 0;
    int fails = 0;
    int busy_ready = 0;
    int last_rd, last_wr;
    int hits = 0, misses = 0;

    generate
        for (genvar g = 0; g < N; g++) begin : g_dut
            cache_ctrl #(.WAYS((g == 2) ? 1 : 2), .WRITE_BACK((g == 1) ? 1'b0 : 1'b1)) u0 (
                .clk(clk), .rst(rst),
                .cpu_req_valid(req_valid[g]), .cpu_req_ready(req_ready[g]),
                .cpu_req_we(req_we[g]), .cpu_req_addr(req_addr[g]), .cpu_req_wdata(req_wdata[g]),
                .cpu_rsp_valid(rsp_valid[g]), .cpu_rsp_rdata(rsp_rdata[g]), .cpu_rsp_hit(rsp_hit[g]),
                .mem_req_valid(mreq_valid[g]), .mem_req_ready(mreq_ready[g]),
                .mem_req_we(mreq_we[g]), .mem_req_addr(mreq_addr[g]), .mem_req_wdata(mreq_wdata[g]),
                .mem_rsp_valid(mrsp_valid[g]), .mem_rsp_rdata(mrsp_rdata[g])
            );
        end
    endgenerate

    function automatic logic [DW-1:0] init_word(input int a);
        return 32'h5A00_0000 + 32'(a) * 32'h0001_0101;
    endfunction

    // backing memory model, one process for all instances
    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < N; k++) begin
                for (int a = 0; a < DEPTH; a++) mem_b[k][a] <= init_word(a);
                pend[k] <= 1'b0; pend_addr[k] <= '0;
                mrsp_valid[k] <= 1'b0; mrsp_rdata[k] <= '0; mreq_ready[k] <= 1'b1;
                mem_rd_cnt[k] <= 0; mem_wr_cnt[k] <= 0; rsp_cnt[k] <= 0;
            end
        end else begin
            for (int k = 0; k < N; k++) begin
                mreq_ready[k] <= ($urandom % 4) != 0;
                mrsp_valid[k] <= 1'b0;
                if (mreq_valid[k] && mreq_ready[k]) begin
                    if (mreq_we[k]) begin
                        mem_b[k][mreq_addr[k]] <= mreq_wdata[k];
                        mem_wr_cnt[k] <= mem_wr_cnt[k] + 1;
                    end else begin
                        pend[k] <= 1'b1;
                        pend_addr[k] <= mreq_addr[k];
                        mem_rd_cnt[k] <= mem_rd_cnt[k] + 1;
                    end
                end
                if (pend[k]) begin
                    mrsp_valid[k] <= 1'b1;
                    mrsp_rdata[k] <= mem_b[k][pend_addr[k]];
                    pend[k] <= 1'b0;
                end
                if (rsp_valid[k]) rsp_cnt[k] <= rsp_cnt[k] + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string what, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", what, got, exp);
        end
    endtask

    task automatic access(input int k, input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          output logic [DW-1:0] q, output bit h);
        int rd0, wr0;
        rd0 = mem_rd_cnt[k];
        wr0 = mem_wr_cnt[k];
        @(negedge clk);
        req_valid[k] = 1'b1; req_we[k] = we; req_addr[k] = a; req_wdata[k] = d;
        while (!req_ready[k]) @(negedge clk);
        @(negedge clk);
        req_valid[k] = 1'b0;
        while (!rsp_valid[k]) begin
            if (req_ready[k]) busy_ready++;
            @(negedge clk);
        end
        q = rsp_rdata[k];
        h = rsp_hit[k];
        if (we) ref_mem[k][a] = d;
        req_cnt[k]++;
        if (h) hits++; else misses++;
        last_rd = mem_rd_cnt[k] - rd0;
        last_wr = mem_wr_cnt[k] - wr0;
    endtask

    // read and compare data and hit flag
    task automatic rd_chk(input int k, input logic [AW-1:0] a, input bit exp_hit, input string tag);
        logic [DW-1:0] q; bit h;
        access(k, 1'b0, a, '0, q, h);
        chk(q == ref_mem[k][a], $sformatf("%s data @%h dut%0d", tag, a, k), q, ref_mem[k][a]);
        chk(h == exp_hit, $sformatf("%s hit @%h dut%0d", tag, a, k), 32'(h), 32'(exp_hit));
    endtask

    task automatic wr_do(input int k, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input bit exp_hit, input string tag);
        logic [DW-1:0] q; bit h;
        access(k, 1'b1, a, d, q, h);
        chk(h == exp_hit, $sformatf("%s write hit @%h dut%0d", tag, a, k), 32'(h), 32'(exp_hit));
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL R9 watchdog: actual %0d expected %0d responses", rsp_cnt[0], req_cnt[0]);
        finish_run();
    end

    initial begin
        void'($urandom(32'd1207));
        for (int k = 0; k < N; k++) begin
            req_valid[k] = 1'b0; req_we[k] = 1'b0; req_addr[k] = '0; req_wdata[k] = '0;
            req_cnt[k] = 0;
            for (int a = 0; a < DEPTH; a++) ref_mem[k][a] = init_word(a);
        end
        rst = 1'b1;
        repeat (4) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        for (int k = 0; k < N; k++) begin
            chk(req_ready[k] == 1'b1, "R10 ready after reset", 32'(req_ready[k]), 32'd1);
            chk(rsp_valid[k] == 1'b0, "R10 no response after reset", 32'(rsp_valid[k]), 32'd0);
        end

        // R3 / R10: first read misses and fetches the whole block
        rd_chk(0, 10'h010, 1'b0, "R10 R3");
        chk(last_rd == 4, "R3 fill beats", 32'(last_rd), 32'd4);
        // R2 hit in same block, no traffic
        rd_chk(0, 10'h013, 1'b1, "R2");
        chk(last_rd == 0 && last_wr == 0, "R2 no memory traffic", 32'(last_rd + last_wr), 32'd0);
        // R1 same tag, other set is another line; other tag same set too
        rd_chk(0, 10'h014, 1'b0, "R1 set field");
        rd_chk(0, 10'h020, 1'b0, "R1 tag field");
        rd_chk(0, 10'h011, 1'b1, "R1 both ways resident");
        // R4 least recently used replacement
        rd_chk(0, 10'h030, 1'b0, "R4 miss evicts 0x02x");
        rd_chk(0, 10'h012, 1'b1, "R4 recent line kept");
        rd_chk(0, 10'h021, 1'b0, "R4 evicted line misses");
        rd_chk(0, 10'h031, 1'b0, "R4 second eviction");
        // R6 write-back write miss allocates, clean victim
        wr_do(0, 10'h041, 32'hDEAD_0041, 1'b0, "R6");
        chk(last_rd == 4 && last_wr == 0, "R6 allocate traffic", 32'(last_rd * 16 + last_wr), 32'h40);
        rd_chk(0, 10'h041, 1'b1, "R6 merged store");
        chk(mem_b[0][10'h041] == init_word(10'h041), "R5 memory untouched by store",
            mem_b[0][10'h041], init_word(10'h041));
        // R5 clean eviction then dirty eviction
        rd_chk(0, 10'h050, 1'b0, "R5 clean victim");
        chk(last_wr == 0, "R5 clean victim no write", 32'(last_wr), 32'd0);
        rd_chk(0, 10'h060, 1'b0, "R5 dirty victim");
        chk(last_wr == 4, "R5 dirty write-back beats", 32'(last_wr), 32'd4);
        chk(mem_b[0][10'h041] == 32'hDEAD_0041, "R5 written back data", mem_b[0][10'h041], 32'hDEAD_0041);
        wr_do(0, 10'h061, 32'hBEEF_0061, 1'b1, "R5");
        chk(last_wr == 0, "R5 write hit no memory write", 32'(last_wr), 32'd0);
        rd_chk(0, 10'h061, 1'b1, "R5 write hit data");

        // R7 write-through instance
        wr_do(1, 10'h010, 32'hCAFE_0010, 1'b0, "R7");
        chk(last_wr == 1 && last_rd == 0, "R7 write miss traffic", 32'(last_wr * 16 + last_rd), 32'h10);
        chk(mem_b[1][10'h010] == 32'hCAFE_0010, "R7 memory updated", mem_b[1][10'h010], 32'hCAFE_0010);
        rd_chk(1, 10'h010, 1'b0, "R7 no allocate");
        wr_do(1, 10'h011, 32'hCAFE_0011, 1'b1, "R7");
        chk(last_wr == 1, "R7 write hit also to memory", 32'(last_wr), 32'd1);
        rd_chk(1, 10'h011, 1'b1, "R7 write hit data");

        // R11 direct mapped instance
        rd_chk(2, 10'h010, 1'b0, "R11");
        rd_chk(2, 10'h020, 1'b0, "R11");
        rd_chk(2, 10'h010, 1'b0, "R11 conflict overwrite");
        wr_do(2, 10'h010, 32'hF00D_0010, 1'b1, "R11");
        rd_chk(2, 10'h020, 1'b0, "R11 dirty evicted");
        chk(last_wr == 4, "R11 write-back beats", 32'(last_wr), 32'd4);
        chk(mem_b[2][10'h010] == 32'hF00D_0010, "R11 written back data", mem_b[2][10'h010], 32'hF00D_0010);

        // random traffic against the reference memory (R2 R3 R5 R6 R7)
        for (int k = 0; k < N; k++) begin
            for (int i = 0; i < 300; i++) begin
                logic [AW-1:0] a;
                logic [DW-1:0] q;
                bit h;
                a = AW'(((($urandom % 6) + 1) << 4) | ($urandom % 16));
                if (($urandom % 3) == 0) begin
                    access(k, 1'b1, a, $urandom, q, h);
                end else begin
                    access(k, 1'b0, a, '0, q, h);
                    chk(q == ref_mem[k][a], $sformatf("R2 R3 random read @%h dut%0d", a, k), q, ref_mem[k][a]);
                end
            end
        end
        begin
            int bad = 0;
            for (int a = 0; a < 128; a++) if (mem_b[1][a] != ref_mem[1][a]) bad++;
            chk(bad == 0, "R7 memory matches every write", 32'(bad), 32'd0);
        end

        // R8 / R9 bookkeeping at the ports
        chk(busy_ready == 0, "R8 ready low while busy", 32'(busy_ready), 32'd0);
        repeat (3) @(negedge clk);
        for (int k = 0; k < N; k++)
            chk(rsp_cnt[k] == req_cnt[k], $sformatf("R9 one response per request dut%0d", k),
                32'(rsp_cnt[k]), 32'(req_cnt[k]));
        $display("[TB] hits %0d misses %0d", hits, misses);
        finish_run();
    end

endmodule